// File: doc/BRIEF.md
# Page Write Buffer and Write-Cycle Timer

This block sits behind a serial memory slave front end. Once the front end has decoded a memory address it loads that address here. Each data byte that follows is then parked in a page-sized buffer. The low address bits step forward after every byte and wrap inside the page, so a long burst overwrites the bytes it wrote earlier. Per-entry valid flags record which page slots hold data.

A stop pulse ends the burst. If at least one byte was collected, the block starts a write cycle of programmable length and raises `busy` for the whole of it. In the first page-length cycles of that window it walks the page slots in ascending order. It issues one memory write for each filled slot, except when the write-protect level is high and the page lies in the top eighth of the array. While `busy` is high, every front-end command is dropped. A stop with no bytes behind it, as after an address-only transfer, starts nothing.

The cycle length is chosen at the stop from two clock-count parameters by a supply-range input. Both counts must be at least the page size, so that the page walk fits inside the busy window.

Top module: `page_wr_buffer`

## Requirements
- R1: After reset `busy` is 0, `mem_we` is 0 and `next_addr` is 0.
- R2: Each byte strobed while idle is buffered at page offset `next_addr[PAGE_W-1:0]`. The offset then grows by one modulo the page size, and the page bits of `next_addr` do not change.
- R3: When a burst covers a page offset more than once, exactly one write reaches that offset, carrying the last byte sent to it.
- R4: A stop while idle with at least one buffered byte raises `busy` on the next cycle. `busy` then stays high for exactly `CYC_HI` cycles when `low_supply` was 0 at the stop, or `CYC_LO` cycles when it was 1.
- R5: A stop with no buffered byte leaves `busy` low and issues no memory write.
- R6: Memory writes occur only while `busy` is high, and only within the loaded page. There is exactly one write per filled slot, in ascending offset order.
- R7: While `busy` is high, `addr_load`, `byte_vld` and `stop_pulse` have no effect. `next_addr`, the busy length and the buffer contents are unchanged, and no later write carries a byte sent during busy.
- R8: When `wp_level` is 1 at a write slot and address bits [ADDR_W-1:ADDR_W-3] of the page are all ones, that write is suppressed. Pages outside that top eighth are written whatever the level of `wp_level`.
- R9: After a write cycle, `next_addr` holds the loaded page with the offset one past the last byte received, wrapped within the page.
- R10: An address load while idle sets `next_addr` to `addr_in` and discards bytes buffered since the previous load, so they are never written.
- R11: In one cycle, `addr_load` takes precedence over `byte_vld`, which takes precedence over `stop_pulse`. Only the highest one present acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load `addr_in` as the start address of a burst |
| addr_in | input | ADDR_W | Memory start address |
| byte_vld | input | 1 | One data byte is present on `byte_in` |
| byte_in | input | DATA_W | Data byte |
| stop_pulse | input | 1 | Stop condition seen by the front end |
| wp_level | input | 1 | Write-protect level, used unlatched at each write |
| low_supply | input | 1 | Selects the longer cycle count when 1 |
| busy | output | 1 | Write cycle in progress |
| next_addr | output | ADDR_W | Current page and offset of the address counter |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
The hardest case to reach from the ports is front-end traffic that lands while the cycle is running. This includes a stop, a byte or an address load arriving on the final busy cycle, where a slip of one cycle would restart the timer or leak a byte into the next page commit. Random transactions therefore inject random commands on random busy cycles, including the last one. A following transaction then checks that it commits only its own bytes. Directed bursts longer than a page, starting near the page end, cover the wrap-and-overwrite case, and random start addresses biased toward the top eighth exercise protection with both protect levels.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    // one decoded front-end command per cycle
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_BYTE = 2'd2,
        CMD_STOP = 2'd3
    } wpb_cmd_e;

endpackage

// File: rtl/wpb_timer.sv
module wpb_timer #(
    parameter int CYC_HI = 2000000,
    parameter int CYC_LO = 3000000,
    parameter int CNT_W  = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic low_supply,
    output logic busy,
    output logic done
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.busy) begin
            if (cur_q.cnt == '0) nxt_d.busy = 1'b0;
            else                 nxt_d.cnt  = cur_q.cnt - 1'b1;
        end else if (start) begin
            nxt_d.busy = 1'b1;
            nxt_d.cnt  = low_supply ? CNT_W'(CYC_LO - 1) : CNT_W'(CYC_HI - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign busy = cur_q.busy;
    assign done = cur_q.busy && (cur_q.cnt == '0);

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.busy && cur_q.cnt != '0 |=> cur_q.busy && cur_q.cnt == $past(cur_q.cnt) - 1'b1);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.busy && !start |=> !cur_q.busy);

endmodule

// File: rtl/wpb_page_buf.sv
module wpb_page_buf
    import wpb_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8,
    localparam int PAGE_SZ = 1 << PAGE_W,
    localparam int PG_W    = ADDR_W - PAGE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  wpb_cmd_e                       cmd,
    input  logic [ADDR_W-1:0]              addr_in,
    input  logic [DATA_W-1:0]              byte_in,
    input  logic                           done,
    output logic [PG_W-1:0]                page,
    output logic [PAGE_W-1:0]              off,
    output logic [PAGE_SZ-1:0]             vld,
    output logic [PAGE_SZ-1:0][DATA_W-1:0] data
);

    typedef struct packed {
        logic [PG_W-1:0]                page;
        logic [PAGE_W-1:0]              off;
        logic [PAGE_SZ-1:0]             vld;
        logic [PAGE_SZ-1:0][DATA_W-1:0] data;
    } buf_t;

    buf_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (done) begin
            nxt_d.vld = '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    nxt_d.page = addr_in[ADDR_W-1:PAGE_W];
                    nxt_d.off  = addr_in[PAGE_W-1:0];
                    nxt_d.vld  = '0;
                end
                CMD_BYTE: begin
                    nxt_d.data[cur_q.off] = byte_in;
                    nxt_d.vld[cur_q.off]  = 1'b1;
                    nxt_d.off             = cur_q.off + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign page = cur_q.page;
    assign off  = cur_q.off;
    assign vld  = cur_q.vld;
    assign data = cur_q.data;

    // R2
    off_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_BYTE && !done |=> cur_q.off == $past(cur_q.off) + 1'b1 && $stable(cur_q.page));

    // R7
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_NONE && !done |=> $stable(cur_q.vld) && $stable(cur_q.off) && $stable(cur_q.data));

endmodule

// File: rtl/wpb_commit.sv
module wpb_commit #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8,
    parameter int PROT_W = 3,
    localparam int PAGE_SZ = 1 << PAGE_W,
    localparam int PG_W    = ADDR_W - PAGE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [PG_W-1:0]                page,
    input  logic [PAGE_SZ-1:0]             vld,
    input  logic [PAGE_SZ-1:0][DATA_W-1:0] data,
    input  logic                           wp_level,
    output logic                           scanning,
    output logic                           mem_we,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic [DATA_W-1:0]              mem_wdata
);

    typedef struct packed {
        logic              scan;
        logic [PAGE_W-1:0] idx;
    } scan_t;

    scan_t cur_q, nxt_d;
    logic  in_prot;

    // protected region: top PROT_W address bits all ones
    assign in_prot = &page[PG_W-1 -: PROT_W];

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.scan) begin
            if (cur_q.idx == '1) nxt_d.scan = 1'b0;
            nxt_d.idx = cur_q.idx + 1'b1;
        end else if (start) begin
            nxt_d.scan = 1'b1;
            nxt_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign scanning  = cur_q.scan;
    assign mem_we    = cur_q.scan && vld[cur_q.idx] && !(wp_level && in_prot);
    assign mem_addr  = {page, cur_q.idx};
    assign mem_wdata = data[cur_q.idx];

    // R6
    scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.scan && cur_q.idx != '1 |=> cur_q.scan && cur_q.idx == $past(cur_q.idx) + 1'b1);

endmodule

// File: rtl/page_wr_buffer.sv
module page_wr_buffer
    import wpb_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8,
    parameter int PROT_W = 3,
    parameter int CYC_HI = 2000000,
    parameter int CYC_LO = 3000000,
    localparam int PAGE_SZ = 1 << PAGE_W,
    localparam int PG_W    = ADDR_W - PAGE_W,
    localparam int CYC_MAX = (CYC_HI > CYC_LO) ? CYC_HI : CYC_LO,
    localparam int CNT_W   = $clog2(CYC_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              stop_pulse,
    input  logic              wp_level,
    input  logic              low_supply,
    output logic              busy,
    output logic [ADDR_W-1:0] next_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    wpb_cmd_e                       cmd;
    logic                           start;
    logic                           done;
    logic                           scanning;
    logic                           vld_any;
    logic [PG_W-1:0]                page;
    logic [PAGE_W-1:0]              off;
    logic [PAGE_SZ-1:0]             vld;
    logic [PAGE_SZ-1:0][DATA_W-1:0] data;

    // front-end commands are dropped during the cycle; load > byte > stop
    always_comb begin
        if (busy)            cmd = CMD_NONE;
        else if (addr_load)  cmd = CMD_LOAD;
        else if (byte_vld)   cmd = CMD_BYTE;
        else if (stop_pulse) cmd = CMD_STOP;
        else                 cmd = CMD_NONE;
    end

    assign vld_any   = |vld;
    assign start     = (cmd == CMD_STOP) && vld_any;
    assign next_addr = {page, off};

    wpb_page_buf #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .addr_in (addr_in),
        .byte_in (byte_in),
        .done    (done),
        .page    (page),
        .off     (off),
        .vld     (vld),
        .data    (data)
    );

    wpb_timer #(
        .CYC_HI (CYC_HI),
        .CYC_LO (CYC_LO),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .low_supply (low_supply),
        .busy       (busy),
        .done       (done)
    );

    wpb_commit #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W),
        .PROT_W (PROT_W)
    ) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .page      (page),
        .vld       (vld),
        .data      (data),
        .wp_level  (wp_level),
        .scanning  (scanning),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R6
    we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R6
    scan_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> busy);

    // R5
    busy_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(vld_any));

    // R7
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(next_addr));

endmodule

// File: tb/page_wr_buffer_bench.sv
module page_wr_buffer_bench;

    localparam int ADDR_W  = 15;
    localparam int PAGE_W  = 6;
    localparam int DATA_W  = 8;
    localparam int CYC_HI  = 90;
    localparam int CYC_LO  = 130;
    localparam int PAGE_SZ = 1 << PAGE_W;
    localparam int PG_W    = ADDR_W - PAGE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              addr_load = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              byte_vld = 1'b0;
    logic [DATA_W-1:0] byte_in = '0;
    logic              stop_pulse = 1'b0;
    logic              wp_level = 1'b0;
    logic              low_supply = 1'b0;
    logic              busy;
    logic [ADDR_W-1:0] next_addr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    always #2.5 clk = ~clk;

    page_wr_buffer #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W),
        .PROT_W (3),
        .CYC_HI (CYC_HI),
        .CYC_LO (CYC_LO)
    ) u_page_wr_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_load  (addr_load),
        .addr_in    (addr_in),
        .byte_vld   (byte_vld),
        .byte_in    (byte_in),
        .stop_pulse (stop_pulse),
        .wp_level   (wp_level),
        .low_supply (low_supply),
        .busy       (busy),
        .next_addr  (next_addr),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench model, built from the requirements
    logic [PG_W-1:0]   m_page = '0;
    logic [PAGE_W-1:0] m_off  = '0;
    bit                m_vld [PAGE_SZ];
    logic [DATA_W-1:0] m_dat [PAGE_SZ];

    // write monitor
    logic              clr = 1'b0;
    bit                w_seen [PAGE_SZ];
    logic [DATA_W-1:0] w_dat  [PAGE_SZ];
    int                w_cnt = 0, w_oop = 0, w_order = 0, w_dup = 0, w_idle = 0;
    int                w_last = -1;

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < PAGE_SZ; i++) w_seen[i] = 1'b0;
            w_cnt = 0; w_oop = 0; w_order = 0; w_dup = 0; w_idle = 0; w_last = -1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            w_cnt++;
            if (!busy) w_idle++;
            if (mem_addr[ADDR_W-1:PAGE_W] != m_page) w_oop++;
            else begin
                if (w_seen[mem_addr[PAGE_W-1:0]]) w_dup++;
                if (int'(mem_addr[PAGE_W-1:0]) <= w_last) w_order++;
                w_seen[mem_addr[PAGE_W-1:0]] = 1'b1;
                w_dat[mem_addr[PAGE_W-1:0]]  = mem_wdata;
                w_last = int'(mem_addr[PAGE_W-1:0]);
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_prot(input logic [PG_W-1:0] pg);
        return &pg[PG_W-1 -: 3];
    endfunction

    task automatic do_load(input logic [ADDR_W-1:0] a);
        addr_in = a; addr_load = 1'b1;
        @(negedge clk);
        addr_load = 1'b0;
        m_page = a[ADDR_W-1:PAGE_W];
        m_off  = a[PAGE_W-1:0];
        for (int i = 0; i < PAGE_SZ; i++) m_vld[i] = 1'b0;
    endtask

    task automatic do_byte(input logic [DATA_W-1:0] d);
        byte_in = d; byte_vld = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0;
        m_vld[m_off] = 1'b1;
        m_dat[m_off] = d;
        m_off = m_off + 1'b1;
    endtask

    // stop, run the cycle, compare; junk injects commands during busy
    task automatic finish_txn(input bit wp, input bit lo, input bit junk, input string tag);
        int  cnt = 0;
        int  exp_cyc;
        int  exp_w = 0;
        int  bad = 0;
        bit  any = 1'b0;
        bit  blk;
        wp_level = wp; low_supply = lo;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int i = 0; i < PAGE_SZ; i++) any |= m_vld[i];
        blk = wp && is_prot(m_page);
        exp_cyc = any ? (lo ? CYC_LO : CYC_HI) : 0;
        stop_pulse = 1'b1;
        @(negedge clk);
        stop_pulse = 1'b0;
        while (busy && cnt < 1000) begin
            cnt++;
            if (junk && ($urandom_range(0, 3) == 0 || cnt == exp_cyc)) begin
                addr_in    = ADDR_W'($urandom);
                byte_in    = DATA_W'($urandom);
                addr_load  = ($urandom_range(0, 2) == 0);
                byte_vld   = ($urandom_range(0, 1) == 0);
                stop_pulse = ($urandom_range(0, 1) == 0);
            end
            @(negedge clk);
            addr_load = 1'b0; byte_vld = 1'b0; stop_pulse = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(cnt == exp_cyc, {tag, " R4/R5 busy length"}, cnt, exp_cyc);
        for (int i = 0; i < PAGE_SZ; i++) begin
            bit ew = m_vld[i] && !blk;
            if (ew) exp_w++;
            if (w_seen[i] != ew || (ew && w_dat[i] !== m_dat[i])) begin
                if (bad == 0)
                    $display("FAIL %s R3/R8 offset %0d actual=%0h/%0h expected=%0h/%0h",
                             tag, i, w_seen[i], w_dat[i], ew, m_dat[i]);
                bad++;
            end
        end
        n_chk++;
        if (bad != 0) n_bad++;
        check(w_cnt == exp_w && w_oop == 0 && w_dup == 0, {tag, " R6 write count"}, w_cnt, exp_w);
        check(w_order == 0 && w_idle == 0, {tag, " R6 order and busy window"}, w_order + w_idle, 0);
        check(next_addr == {m_page, m_off}, {tag, " R9/R7 next_addr"}, next_addr, {m_page, m_off});
        for (int i = 0; i < PAGE_SZ; i++) m_vld[i] = 1'b0;
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        for (int i = 0; i < PAGE_SZ; i++) begin m_vld[i] = 1'b0; m_dat[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(busy == 1'b0 && mem_we == 1'b0, "R1 reset busy/we", {busy, mem_we}, 0);
        check(next_addr == '0, "R1 reset next_addr", next_addr, 0);

        // R5: address-only transfer then stop
        do_load(15'h0123);
        finish_txn(1'b0, 1'b0, 1'b0, "dummy");

        // R2: single byte
        do_load(15'h0040);
        do_byte(8'hA5);
        check(next_addr == 15'h0041, "R2 offset step", next_addr, 15'h0041);
        finish_txn(1'b0, 1'b0, 1'b0, "single");

        // R3: burst from offset 60 longer than a page
        do_load(15'h1A7C);
        for (int i = 0; i < 70; i++) do_byte(DATA_W'(i * 3 + 1));
        check(next_addr == {9'(15'h1A7C >> 6), 6'(60 + 70)}, "R2/R3 wrap offset",
              next_addr, {9'(15'h1A7C >> 6), 6'(60 + 70)});
        finish_txn(1'b0, 1'b1, 1'b0, "wrap");

        // R8: protected page, protect high then low
        do_load(15'h7F80);
        for (int i = 0; i < 5; i++) do_byte(DATA_W'(8'h30 + i));
        finish_txn(1'b1, 1'b0, 1'b0, "prot_on");
        do_load(15'h7F80);
        for (int i = 0; i < 5; i++) do_byte(DATA_W'(8'h50 + i));
        finish_txn(1'b0, 1'b0, 1'b0, "prot_off");
        // R8: unprotected page with protect high
        do_load(15'h6FC0);
        for (int i = 0; i < 4; i++) do_byte(DATA_W'(8'h70 + i));
        finish_txn(1'b1, 1'b1, 1'b0, "wp_low_region");

        // R10: reload discards pending bytes
        do_load(15'h0200);
        for (int i = 0; i < 3; i++) do_byte(8'hEE);
        do_load(15'h0305);
        check(next_addr == 15'h0305, "R10 reload next_addr", next_addr, 15'h0305);
        do_byte(8'h11); do_byte(8'h22);
        finish_txn(1'b0, 1'b0, 1'b0, "reload");

        // R11: load beats byte, byte beats stop
        addr_in = 15'h0480; byte_in = 8'h99; addr_load = 1'b1; byte_vld = 1'b1;
        @(negedge clk);
        addr_load = 1'b0; byte_vld = 1'b0;
        m_page = 9'(15'h0480 >> 6); m_off = '0;
        check(next_addr == 15'h0480, "R11 load over byte", next_addr, 15'h0480);
        byte_in = 8'h5C; byte_vld = 1'b1; stop_pulse = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0; stop_pulse = 1'b0;
        m_vld[0] = 1'b1; m_dat[0] = 8'h5C; m_off = 6'd1;
        check(busy == 1'b0 && next_addr == 15'h0481, "R11 byte over stop",
              {busy, next_addr}, {1'b0, 15'h0481});
        finish_txn(1'b0, 1'b0, 1'b0, "prio");

        // R7: commands during busy, then random mix
        for (int t = 0; t < 36; t++) begin
            logic [ADDR_W-1:0] a = ADDR_W'($urandom);
            int n;
            if ($urandom_range(0, 3) == 0) a[ADDR_W-1 -: 3] = 3'b111;
            n = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 80);
            do_load(a);
            for (int i = 0; i < n; i++) do_byte(DATA_W'($urandom));
            finish_txn(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)), "rand");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule